// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a small synchronous burst SRAM in which reads and writes can follow each other on every clock with no idle cycles between them. It registers the address and control inputs on the rising clock edge. Read data comes straight out of the array in the next cycle, with no extra output register. A write takes its data and byte selects one edge after its address. During that data cycle the output driver is held off, so the shared data bus never has two drivers.

A host selects the device with three synchronous chip enables and sets the operation with a write enable. An advance/load control either starts a new access or continues the current one as a burst. The burst runs over the low two address bits, in linear or interleaved order. A clock enable freezes the whole pipeline. An asynchronous output enable gates only the drive flag. The bidirectional data bus is represented by separate `din`, `dout` and `dout_oe` ports.

Top module: `zt_sram`

## Requirements
- R1: A read is a load cycle (`adv_ld`=0) with the device selected and `we_n`=1. It is registered on a rising edge. In the following cycle `dout` shows the stored word at that address and `dout_oe` is 1 while `oe_n` is 0.
- R2: On an edge where `clk_en` is 0, no register or array word changes. `dout` keeps its value, and so does `dout_oe` while `oe_n` is steady.
- R3: The device is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0 all hold at the same time. Any other combination on a load cycle is a deselect, and `dout_oe` is 0 in the next cycle.
- R4: The data of a write and its `byte_we_n` are sampled on the edge after the write address. Lane n is bits [9n+8:9n], and it is written when `byte_we_n[n]`=0. A lane whose select is 1 keeps its old value.
- R5: Reads and writes may alternate on consecutive cycles. A read loaded on the same edge that completes a write to that address returns the newly merged word.
- R6: In the cycle after a write address is registered (its data cycle), `dout_oe` is 0.
- R7: An advance cycle (`adv_ld`=1) repeats the operation of the running access at the next burst address. The chip enables, `we_n` and `burst_mode` are ignored on an advance cycle. An advance after a deselect stays deselected.
- R8: With `burst_mode`=0 latched at load, beat k uses low bits (start+k) mod 4, and address bits [3:2] stay at their loaded value.
- R9: With `burst_mode`=1 latched at load, beat k uses low bits start XOR k.
- R10: `oe_n`=1 forces `dout_oe` to 0 at once, without waiting for a clock edge. It has no effect on the array or on sequencing.
- R11: After reset (`rst_n` low on an edge) `dout_oe` is 0 and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock qualifier; 0 freezes all state |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 = write, 1 = read on a load cycle |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new access |
| burst_mode | input | 1 | 0 = linear, 1 = interleaved (latched on load) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 4 | Word address |
| byte_we_n | input | 4 | Per-lane write selects, active low, taken in the data cycle |
| din | input | 36 | Write data, taken in the data cycle |
| dout | output | 36 | Flow-through read data |
| dout_oe | output | 1 | Output drive enable standing in for the tri-state |

## Verification
Two actions can fall on the same clock edge: the completion of one write, with its data and lane selects taken, and the registration of the next access, read or write. The bench provokes this with pipelined writes that chain back to back, and with a read of the just-written address loaded on the very edge that delivers the write data. It then checks that `dout` in the next cycle carries the merged word. The same overlap is also provoked while `clk_en` is low, where neither the pending write nor the new command may take effect.

// File: rtl/zt_sram_pkg.sv
// Package: shared operation type and the burst-order function.
// Assumes the burst field is narrow (a few bits) so the adder/XOR is shallow.
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zt_op_e;

    // Low address bits for beat k of a burst beginning at start.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] k,
                                             input logic       interleave);
        burst_low = interleave ? (start ^ k) : (start + k);
    endfunction

endpackage

// File: rtl/zt_burst_ctr.sv
// Burst sequencer: latches the start offset and order on load, counts beats
// on advance, and presents the current low address bits.
// Assumes load and step are never asserted together.
module zt_burst_ctr #(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             load,
    input  logic             step,
    input  logic [LOW_W-1:0] start,
    input  logic             interleave,
    output logic [LOW_W-1:0] low
);
    logic [LOW_W-1:0] start_q;
    logic [LOW_W-1:0] cnt_q;
    logic             mode_q;

    // Capture start/order on load, bump the beat count on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
        end else if (clk_en) begin
            if (load) begin
                start_q <= start;
                cnt_q   <= '0;
                mode_q  <= interleave;
            end else if (step) begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Combine start and count in the latched order.
    always_comb begin
        low = mode_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
    end
endmodule

// File: rtl/zt_array.sv
// Storage: WORDS x (LANES*LANE_W) register file with per-lane write enables
// and an asynchronous read port (flow-through). Cleared by reset.
module zt_array #(
    parameter int AW     = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int WORDS = 1 << AW;

    logic [LANE_W-1:0] mem [WORDS][LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Write one lane of the addressed word when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) mem[w][g] <= '0;
            end else if (wr_en && lane_we[g]) begin
                mem[wr_addr][g] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Read the lane of the addressed word without a register.
        always_comb begin
            rd_data[g*LANE_W +: LANE_W] = mem[rd_addr][g];
        end
    end
endmodule

// File: rtl/zt_sram.sv
// Top: zero-turnaround flow-through SRAM. Registers address/control on the
// rising edge; the write data follows one edge later and is committed on that
// edge; the drive flag is off during a write data cycle and while deselected.
// Assumes a single clock domain and synchronous active-low reset.
module zt_sram #(
    parameter int ADDR_W  = 4,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    ce0_n,
    input  logic                    ce1,
    input  logic                    ce2_n,
    input  logic                    we_n,
    input  logic                    adv_ld,
    input  logic                    burst_mode,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        byte_we_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    import zt_sram_pkg::*;

    localparam int DATA_W = LANES * LANE_W;
    localparam int HIGH_W = ADDR_W - BURST_W;

    zt_op_e            op_q;
    logic [HIGH_W-1:0] base_q;
    logic [BURST_W-1:0] low;
    logic [ADDR_W-1:0] cur_addr;
    logic              selected;
    logic              load;
    logic              wr_now;

    // Decode the chip enables and the access kind.
    always_comb begin
        selected = !ce0_n && ce1 && !ce2_n;
        load     = !adv_ld;
        wr_now   = clk_en && (op_q == OP_WRITE);
        cur_addr = {base_q, low};
    end

    // Register the operation and upper address bits of each new access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            base_q <= '0;
        end else if (clk_en && load) begin
            op_q   <= !selected ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
            base_q <= addr[ADDR_W-1:BURST_W];
        end
    end

    zt_burst_ctr #(.LOW_W(BURST_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .load       (load),
        .step       (adv_ld),
        .start      (addr[BURST_W-1:0]),
        .interleave (burst_mode),
        .low        (low)
    );

    zt_array #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_now),
        .wr_addr (cur_addr),
        .lane_we (~byte_we_n),
        .wr_data (din),
        .rd_addr (cur_addr),
        .rd_data (dout)
    );

    // Drive only in a read cycle and only while the output enable is on.
    always_comb begin
        dout_oe = (op_q == OP_READ) && !oe_n;
    end

    logic [DATA_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/zt_sram_chk.sv
// Checker: port-level temporal properties of zt_sram, bound to every instance.
module zt_sram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clk_en,
    input logic        ce0_n,
    input logic        ce1,
    input logic        ce2_n,
    input logic        we_n,
    input logic        adv_ld,
    input logic        oe_n,
    input logic [35:0] dout,
    input logic        dout_oe
);
    logic past_ok;
    logic sel;

    // Mark that the previous edge was taken out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    assign sel = !ce0_n && ce1 && !ce2_n;

    assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && sel && we_n) |=> (dout_oe == !oe_n));

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(clk_en) && $stable(oe_n)) |-> ($stable(dout) && $stable(dout_oe)));

    assert_deselect_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && !sel) |=> !dout_oe);

    assert_write_turnoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && sel && !we_n) |=> !dout_oe);

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_oe);
endmodule

bind zt_sram zt_sram_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .ce0_n   (ce0_n),
    .ce1     (ce1),
    .ce2_n   (ce2_n),
    .we_n    (we_n),
    .adv_ld  (adv_ld),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/zt_sram_tb.sv
// Directed bench for zt_sram: one task per scenario, each checking its results.
module zt_sram_tb;
    localparam logic [2:0] SEL = 3'b010; // {ce2_n, ce1, ce0_n}

    logic        clk = 1'b0;
    logic        rst_n, clk_en, ce0_n, ce1, ce2_n, we_n, adv_ld, burst_mode, oe_n;
    logic [3:0]  addr, byte_we_n;
    logic [35:0] din, dout;
    logic        dout_oe;

    int total = 0;
    int bad   = 0;

    // Bench-side model built from the requirements.
    logic [35:0] refm [16];
    int          m_op;   // 0 idle, 1 read, 2 write
    logic [3:0]  m_base;
    logic [1:0]  m_start, m_k;
    logic        m_mode;

    always #5 clk = ~clk;

    zt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce0_n(ce0_n), .ce1(ce1),
        .ce2_n(ce2_n), .we_n(we_n), .adv_ld(adv_ld), .burst_mode(burst_mode),
        .oe_n(oe_n), .addr(addr), .byte_we_n(byte_we_n), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [35:0] pat(input int i);
        pat = 36'h9_1357_2468 ^ (36'(i) * 36'h0_0F1E_2D3C);
    endfunction

    function automatic logic [3:0] m_cur();
        m_cur = {m_base[3:2], m_mode ? (m_start ^ m_k) : (m_start + m_k)};
    endfunction

    task automatic chk36(string tag, logic [35:0] act, logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: dout=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: dout_oe=%b expected %b", tag, act, exp);
        end
    endtask

    // One clock: drive a command plus data for the previous write, update model.
    task automatic cyc(logic en, logic [2:0] ce, logic we, logic adv, logic [3:0] a,
                       logic [35:0] d, logic [3:0] bw, logic mode);
        clk_en = en; {ce2_n, ce1, ce0_n} = ce; we_n = we; adv_ld = adv;
        addr = a; din = d; byte_we_n = bw; burst_mode = mode;
        @(posedge clk);
        if (en && rst_n) begin
            if (m_op == 2)
                for (int l = 0; l < 4; l++)
                    if (!bw[l]) refm[m_cur()][l*9 +: 9] = d[l*9 +: 9];
            if (adv) m_k = m_k + 2'd1;
            else begin
                m_op = (ce == SEL) ? (we ? 1 : 2) : 0;
                m_base = a; m_start = a[1:0]; m_k = 2'd0; m_mode = mode;
            end
        end
        #1;
    endtask

    task automatic rd_exp(string tag, logic [35:0] exp);
        chk1(tag, dout_oe, 1'b1);
        chk36(tag, dout, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1, 3'b111, 1, 0, 0, 0, 4'hF, 0);
        cyc(1, 3'b111, 1, 0, 0, 0, 4'hF, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) refm[i] = '0;
        m_op = 0; m_base = 0; m_start = 0; m_k = 0; m_mode = 0;
        chk1("R11 reset drive off", dout_oe, 1'b0);
        cyc(1, SEL, 1, 0, 4'd5, 0, 4'hF, 0);
        rd_exp("R11 reset array zero", 36'h0);
    endtask

    task automatic t_alternate();
        cyc(1, SEL, 0, 0, 4'd3, 0, 4'hF, 0);
        chk1("R6 write data cycle off", dout_oe, 1'b0);
        cyc(1, SEL, 1, 0, 4'd3, 36'hA_BCDE_F012, 4'h0, 0);
        rd_exp("R5 read right after write", 36'hA_BCDE_F012);
        cyc(1, SEL, 0, 0, 4'd7, 0, 4'hF, 0);
        chk1("R6 second write off", dout_oe, 1'b0);
        cyc(1, SEL, 1, 0, 4'd3, 36'h1_2345_6789, 4'h0, 0);
        rd_exp("R1 read addr 3 during switch", 36'hA_BCDE_F012);
        cyc(1, SEL, 1, 0, 4'd7, 0, 4'hF, 0);
        rd_exp("R5 read addr 7", 36'h1_2345_6789);
    endtask

    task automatic t_lanes();
        cyc(1, SEL, 0, 0, 4'd3, 0, 4'hF, 0);
        cyc(1, SEL, 1, 0, 4'd3, 36'hF_FFFF_FFFF, 4'b1010, 0);
        rd_exp("R4 lanes 0 and 2 only",
               {9'(36'hA_BCDE_F012 >> 27), 9'h1FF, 9'(36'hA_BCDE_F012 >> 9), 9'h1FF});
        chk36("R4 model agrees", dout, refm[3]);
    endtask

    task automatic t_deselect();
        cyc(1, 3'b011, 1, 0, 4'd7, 0, 4'hF, 0);
        chk1("R3 ce0_n high deselects", dout_oe, 1'b0);
        cyc(1, 3'b000, 1, 0, 4'd7, 0, 4'hF, 0);
        chk1("R3 ce1 low deselects", dout_oe, 1'b0);
        cyc(1, 3'b110, 1, 0, 4'd7, 0, 4'hF, 0);
        chk1("R3 ce2_n high deselects", dout_oe, 1'b0);
        cyc(1, 3'b110, 0, 0, 4'd7, 0, 4'hF, 0);
        cyc(1, SEL, 1, 0, 4'd7, 36'h0_DEAD_0000, 4'h0, 0);
        rd_exp("R3 deselected write not stored", 36'h1_2345_6789);
    endtask

    task automatic t_stall();
        cyc(1, SEL, 1, 0, 4'd7, 0, 4'hF, 0);
        cyc(0, SEL, 0, 0, 4'd2, 36'h5_5555_5555, 4'h0, 1);
        rd_exp("R2 stall holds read", 36'h1_2345_6789);
        cyc(0, 3'b111, 1, 1, 4'd9, 0, 4'h0, 0);
        rd_exp("R2 second stall", 36'h1_2345_6789);
        cyc(1, SEL, 0, 0, 4'd9, 0, 4'hF, 0);
        cyc(0, SEL, 1, 0, 4'd9, 36'h3_3333_3333, 4'h0, 0);
        chk1("R2 stalled data cycle off", dout_oe, 1'b0);
        cyc(1, SEL, 1, 0, 4'd9, 36'h7_0F0F_0F0F, 4'h0, 0);
        rd_exp("R2 stalled edge took no data", 36'h7_0F0F_0F0F);
    endtask

    task automatic t_fill();
        for (int i = 4; i < 12; i++)
            cyc(1, SEL, 0, 0, 4'(i), pat(i - 1), 4'h0, 0);
        cyc(1, 3'b111, 1, 0, 0, pat(11), 4'h0, 0);
        cyc(1, SEL, 1, 0, 4'd11, 0, 4'hF, 0);
        rd_exp("R5 chained writes last word", pat(11));
    endtask

    task automatic t_linear();
        cyc(1, SEL, 1, 0, 4'd6, 0, 4'hF, 0);
        rd_exp("R8 linear beat0 addr6", pat(6));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 1);
        rd_exp("R8 linear beat1 addr7", pat(7));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 1);
        rd_exp("R8 linear beat2 addr4", pat(4));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 1);
        rd_exp("R8 linear beat3 addr5", pat(5));
    endtask

    task automatic t_interleave();
        cyc(1, SEL, 1, 0, 4'd5, 0, 4'hF, 1);
        rd_exp("R9 interleave beat0 addr5", pat(5));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 0);
        rd_exp("R9 interleave beat1 addr4", pat(4));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 0);
        rd_exp("R9 interleave beat2 addr7", pat(7));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 0);
        rd_exp("R9 interleave beat3 addr6", pat(6));
        cyc(1, SEL, 1, 0, 4'd10, 0, 4'hF, 1);
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 0);
        rd_exp("R9 start2 beat1 addr11", pat(11));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 0);
        rd_exp("R9 start2 beat2 addr8", pat(8));
    endtask

    task automatic t_burst_write();
        cyc(1, SEL, 0, 0, 4'd13, 0, 4'hF, 0);
        cyc(1, 3'b111, 1, 1, 0, pat(113), 4'h0, 0);
        chk1("R7 burst write beat off", dout_oe, 1'b0);
        cyc(1, SEL, 1, 1, 0, pat(114), 4'h0, 0);
        cyc(1, SEL, 1, 1, 0, pat(115), 4'h0, 0);
        cyc(1, SEL, 1, 0, 4'd12, pat(112), 4'h0, 0);
        rd_exp("R8 burst write wrapped to 12", pat(112));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 0);
        rd_exp("R7 burst write addr13", pat(113));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 0);
        rd_exp("R7 burst write addr14", pat(114));
        cyc(1, SEL, 1, 1, 0, 0, 4'hF, 0);
        rd_exp("R7 burst write addr15", pat(115));
    endtask

    task automatic t_advance_rules();
        cyc(1, SEL, 1, 0, 4'd8, 0, 4'hF, 0);
        cyc(1, 3'b111, 0, 1, 4'd2, 36'h0_BAD0_0BAD, 4'h0, 0);
        rd_exp("R7 advance ignores enables", pat(9));
        cyc(1, 3'b111, 1, 0, 4'd8, 0, 4'hF, 0);
        cyc(1, SEL, 1, 1, 4'd8, 0, 4'hF, 0);
        chk1("R7 advance after deselect off", dout_oe, 1'b0);
        cyc(1, SEL, 1, 0, 4'd9, 0, 4'hF, 0);
        rd_exp("R7 no write from ignored we_n", pat(9));
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        cyc(1, SEL, 1, 0, 4'd3, 0, 4'hF, 0);
        chk1("R10 oe_n high blocks drive", dout_oe, 1'b0);
        oe_n = 1'b0;
        #1;
        chk1("R10 drive returns without clock", dout_oe, 1'b1);
        chk36("R10 data unaffected", dout, refm[3]);
    endtask

    initial begin
        oe_n = 1'b0;
        t_reset();
        t_alternate();
        t_lanes();
        t_deselect();
        t_stall();
        t_fill();
        t_linear();
        t_interleave();
        t_burst_write();
        t_advance_rules();
        t_oe();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule